// File: doc/BRIEF.md
# Fixed Off-Time Motor Current Regulator

This block closes a current loop around a brushed motor driven by an H-bridge. An external comparator compares the sensed winding current with a control level and raises a digital over-setpoint flag. While the bridge is driving, the regulator waits for that flag. When it appears, the regulator shorts the motor through the two high-side switches for a fixed, programmed number of clock cycles, and the current decays. It then applies drive again in the selected direction. The result is a ripple current around the set level. The ripple grows with the programmed off interval, and it must stay large enough that the comparator does not chatter.

The block produces three bridge commands: a modulation line, a direction line and a brake line. The encodings are: drive = modulation 1, brake 0, direction as selected; high-side short = modulation 1, brake 1, direction 1; all switches off = modulation 0, brake 1, direction 0. The flag is synchronized internally. After each reapplication of drive, a programmable blanking window hides switching spikes from the comparator. An enable input parks the bridge with all switches off.

Top module: `fixed_off_regulator`

## Requirements
- R1: While in drive, an over-setpoint flag first seen high at a rising clock edge puts the outputs into the off phase on the third rising edge counted from that one (two synchronizer flops plus the registered state and outputs).
- R2: During the off phase the outputs are modulation=1, brake=1, direction=1, so both high-side switches are on, whatever the direction select is.
- R3: The off phase lasts exactly N clock cycles, where N is `off_cycles` sampled at the start of the phase. A value of 0 gives one cycle.
- R4: When the off phase ends, drive is applied at once. The flag is then ignored for B cycles, B being `blank_cycles` sampled when the off phase ends. With the flag held high, each drive interval therefore lasts B+1 cycles.
- R5: In drive the outputs are modulation=1 and brake=0, and direction equals `dir_sel` registered once. A change of `dir_sel` shows at the next rising edge and reverses the motor.
- R6: With B=0 and the flag held high, each drive interval still lasts exactly one cycle between off phases, so a minimum ripple always remains.
- R7: A flag pulse that the synchronizer delivers entirely inside the blanking window never starts an off phase.
- R8: `enable` low at a rising edge forces all switches off (modulation=0, brake=1, direction=0) at that edge and returns the controller to idle, and the flag has no effect while disabled. When `enable` rises, drive (starting with blanking) is applied at the next edge.
- R9: After synchronous reset, the outputs show all switches off.
- R10: Changing `off_cycles` during an off phase does not change the length of that phase. The new value applies to the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Regulator enable; low parks the bridge with all switches off |
| dir_sel | input | 1 | Requested drive direction |
| trip_async | input | 1 | Asynchronous over-setpoint flag from the current comparator |
| off_cycles | input | OFF_W | Off-interval length in clock cycles (0 acts as 1) |
| blank_cycles | input | BLANK_W | Flag blanking length after drive is reapplied |
| pwm_o | output | 1 | Bridge modulation command |
| dir_o | output | 1 | Bridge direction command |
| brake_o | output | 1 | Bridge brake command |

## Verification
The bench builds the regulator with an 8-bit off-time field, a 4-bit blanking field and two synchronizer stages. These narrow fields keep every interval short, so a few dozen cycles cover the latency of a single trip pulse, the zero-length off time and the flag held high with and without blanking. With the same fields the bench also runs a trip landing inside the blanking window, a reprogrammed off time in mid-phase, a direction reversal and a disable during an off phase, all well within the run limit.

// File: rtl/fotr_pkg.sv
package fotr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BLANK = 2'd1,
    ST_DRIVE = 2'd2,
    ST_OFF   = 2'd3
  } fotr_state_t;

  typedef struct packed {
    logic pwm;
    logic dir;
    logic brake;
  } bridge_cmd_t;

  // Bridge command for each controller state
  function automatic bridge_cmd_t encode_cmd(input fotr_state_t st, input logic dir_req);
    bridge_cmd_t c;
    case (st)
      ST_BLANK, ST_DRIVE: begin
        c.pwm   = 1'b1;
        c.dir   = dir_req;
        c.brake = 1'b0;
      end
      ST_OFF: begin
        c.pwm   = 1'b1;
        c.dir   = 1'b1;
        c.brake = 1'b1;
      end
      default: begin
        c.pwm   = 1'b0;
        c.dir   = 1'b0;
        c.brake = 1'b1;
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/fotr_sync.sv
module fotr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/fotr_interval.sv
module fotr_interval #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst || clear)       remain <= '0;
    else if (load)          remain <= load_val;
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);

endmodule

// File: rtl/fotr_ctrl.sv
module fotr_ctrl
  import fotr_pkg::*;
#(
  parameter int OFF_W   = 16,
  parameter int BLANK_W = 8,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               trip,
  input  logic [OFF_W-1:0]   off_cycles,
  input  logic [BLANK_W-1:0] blank_cycles,
  input  logic               cnt_expired,
  output fotr_state_t        state_q,
  output fotr_state_t        state_d,
  output logic               cnt_clear,
  output logic               cnt_load,
  output logic [CNT_W-1:0]   cnt_val
);

  logic [OFF_W-1:0]   off_m1;
  logic [BLANK_W-1:0] blank_m1;
  logic               blank_none;

  assign off_m1     = (off_cycles == '0) ? '0 : off_cycles - 1'b1;
  assign blank_m1   = blank_cycles - 1'b1;
  assign blank_none = (blank_cycles == '0);
  assign cnt_clear  = !enable;

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    if (!enable) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE, ST_BLANK: begin
          if (state_q == ST_IDLE || cnt_expired) begin
            if (state_q == ST_IDLE && !blank_none) begin
              state_d  = ST_BLANK;
              cnt_load = 1'b1;
              cnt_val  = CNT_W'(blank_m1);
            end else begin
              state_d = ST_DRIVE;
            end
          end
        end
        ST_DRIVE: begin
          if (trip) begin
            state_d  = ST_OFF;
            cnt_load = 1'b1;
            cnt_val  = CNT_W'(off_m1);
          end
        end
        ST_OFF: begin
          if (cnt_expired) begin
            if (blank_none) begin
              state_d = ST_DRIVE;
            end else begin
              state_d  = ST_BLANK;
              cnt_load = 1'b1;
              cnt_val  = CNT_W'(blank_m1);
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/fotr_cmd_reg.sv
module fotr_cmd_reg
  import fotr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  fotr_state_t state_d,
  input  logic        dir_req,
  output logic        pwm_o,
  output logic        dir_o,
  output logic        brake_o
);

  bridge_cmd_t cmd_d, cmd_q;

  assign cmd_d = encode_cmd(state_d, dir_req);

  always_ff @(posedge clk) begin
    if (rst) cmd_q <= encode_cmd(ST_IDLE, 1'b0);
    else     cmd_q <= cmd_d;
  end

  assign pwm_o   = cmd_q.pwm;
  assign dir_o   = cmd_q.dir;
  assign brake_o = cmd_q.brake;

endmodule

// File: rtl/fixed_off_regulator.sv
module fixed_off_regulator
  import fotr_pkg::*;
#(
  parameter int OFF_W       = 16,
  parameter int BLANK_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               dir_sel,
  input  logic               trip_async,
  input  logic [OFF_W-1:0]   off_cycles,
  input  logic [BLANK_W-1:0] blank_cycles,
  output logic               pwm_o,
  output logic               dir_o,
  output logic               brake_o
);

  localparam int CNT_W = (OFF_W > BLANK_W) ? OFF_W : BLANK_W;

  logic        trip_s;
  logic        cnt_expired;
  logic        cnt_clear;
  logic        cnt_load;
  logic [CNT_W-1:0] cnt_val;
  fotr_state_t state_q;
  fotr_state_t state_d;

  fotr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (trip_async),
    .q   (trip_s)
  );

  fotr_interval #(.W(CNT_W)) u_interval (
    .clk      (clk),
    .rst      (rst),
    .clear    (cnt_clear),
    .load     (cnt_load),
    .load_val (cnt_val),
    .expired  (cnt_expired)
  );

  fotr_ctrl #(.OFF_W(OFF_W), .BLANK_W(BLANK_W), .CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .trip         (trip_s),
    .off_cycles   (off_cycles),
    .blank_cycles (blank_cycles),
    .cnt_expired  (cnt_expired),
    .state_q      (state_q),
    .state_d      (state_d),
    .cnt_clear    (cnt_clear),
    .cnt_load     (cnt_load),
    .cnt_val      (cnt_val)
  );

  fotr_cmd_reg u_cmd (
    .clk     (clk),
    .rst     (rst),
    .state_d (state_d),
    .dir_req (dir_sel),
    .pwm_o   (pwm_o),
    .dir_o   (dir_o),
    .brake_o (brake_o)
  );

endmodule

// File: rtl/fixed_off_regulator_chk.sv
module fixed_off_regulator_chk
  import fotr_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        enable,
  input logic        dir_sel,
  input logic        trip_s,
  input logic        cnt_expired,
  input fotr_state_t state_q,
  input logic        pwm_o,
  input logic        dir_o,
  input logic        brake_o
);

  AST_TRIP_STARTS_OFF: assert property (@(posedge clk) disable iff (rst)
    (enable && state_q == ST_DRIVE && trip_s) |=> (pwm_o && brake_o && dir_o)); // R1

  AST_SHORT_USES_UPPER: assert property (@(posedge clk) disable iff (rst)
    (pwm_o && brake_o) |-> dir_o); // R2

  AST_OFF_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (enable && state_q == ST_OFF && cnt_expired) |=> (state_q != ST_OFF && pwm_o && !brake_o)); // R4

  AST_DRIVE_DIR: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DRIVE || state_q == ST_BLANK) |-> (pwm_o && !brake_o && dir_o == $past(dir_sel))); // R5

  AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (enable && state_q == ST_BLANK && !cnt_expired) |=> (state_q == ST_BLANK)); // R7

  AST_DISABLE_PARKS: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (state_q == ST_IDLE && !pwm_o && brake_o && !dir_o)); // R8

endmodule

bind fixed_off_regulator fixed_off_regulator_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .enable      (enable),
  .dir_sel     (dir_sel),
  .trip_s      (trip_s),
  .cnt_expired (cnt_expired),
  .state_q     (state_q),
  .pwm_o       (pwm_o),
  .dir_o       (dir_o),
  .brake_o     (brake_o)
);

// File: tb/fixed_off_regulator_tb.sv
module fixed_off_regulator_tb;

  localparam int CLK_PERIOD = 10;
  localparam int OFF_W      = 8;
  localparam int BLANK_W    = 4;
  localparam int WATCHDOG   = 20000;

  // observed output kinds
  localparam int K_IDLE  = 0;
  localparam int K_DRIVE = 1;
  localparam int K_OFF   = 2;
  localparam int K_OTHER = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic dir_sel = 1'b0;
  logic trip_async = 1'b0;
  logic [OFF_W-1:0]   off_cycles = '0;
  logic [BLANK_W-1:0] blank_cycles = '0;
  logic pwm_o, dir_o, brake_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fixed_off_regulator #(.OFF_W(OFF_W), .BLANK_W(BLANK_W), .SYNC_STAGES(2)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .dir_sel      (dir_sel),
    .trip_async   (trip_async),
    .off_cycles   (off_cycles),
    .blank_cycles (blank_cycles),
    .pwm_o        (pwm_o),
    .dir_o        (dir_o),
    .brake_o      (brake_o)
  );

  function automatic int kind();
    if (pwm_o && brake_o && dir_o)       return K_OFF;
    if (pwm_o && !brake_o)               return K_DRIVE;
    if (!pwm_o && brake_o && !dir_o)     return K_IDLE;
    return K_OTHER;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_kind(input string req, input int exp);
    int k;
    k = kind();
    check(k == exp, req, k, exp);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_trip();
    trip_async = 1'b1;
    step();
    trip_async = 1'b0;
  endtask

  task automatic run_len(input int k, output int n);
    n = 0;
    while (n < 1000 && kind() == k) begin
      n++;
      step();
    end
  endtask

  task automatic wait_kind(input int k);
    int i;
    i = 0;
    while (i < 200 && kind() != k) begin
      i++;
      step();
    end
  endtask

  task automatic test_reset();
    rst = 1'b1;
    enable = 1'b0;
    repeat (3) step();
    check_kind("R9 reset parks bridge", K_IDLE);
    rst = 1'b0;
    step();
    check_kind("R9 idle after reset release", K_IDLE);
  endtask

  task automatic test_enable_entry();
    blank_cycles = 4'd3;
    off_cycles = 8'd4;
    dir_sel = 1'b1;
    enable = 1'b1;
    step();
    check_kind("R8 drive at first edge after enable", K_DRIVE);
    check(dir_o == 1'b1, "R5 direction follows select", dir_o, 1);
  endtask

  task automatic test_trip_latency();
    int n;
    repeat (6) step();
    pulse_trip();
    check(kind() != K_OFF, "R1 no off after first edge", kind(), K_DRIVE);
    step();
    check(kind() != K_OFF, "R1 no off after second edge", kind(), K_DRIVE);
    step();
    check_kind("R1 off at third edge", K_OFF);
    check(dir_o == 1'b1, "R2 upper short encoding", dir_o, 1);
    run_len(K_OFF, n);
    check(n == 4, "R3 off length 4", n, 4);
    check_kind("R4 drive right after off", K_DRIVE);
  endtask

  task automatic test_zero_off();
    int n;
    off_cycles = 8'd0;
    repeat (6) step();
    pulse_trip();
    step();
    step();
    check_kind("R1 off after zero-length program", K_OFF);
    run_len(K_OFF, n);
    check(n == 1, "R3 zero acts as one cycle", n, 1);
  endtask

  task automatic test_held_high();
    int n;
    off_cycles = 8'd3;
    blank_cycles = 4'd2;
    repeat (6) step();
    trip_async = 1'b1;
    wait_kind(K_OFF);
    run_len(K_OFF, n);
    check(n == 3, "R3 off length under held flag", n, 3);
    run_len(K_DRIVE, n);
    check(n == 3, "R4 drive lasts blank+1 under held flag", n, 3);
    blank_cycles = 4'd0;
    run_len(K_OFF, n);
    check(n == 3, "R3 off length second period", n, 3);
    run_len(K_DRIVE, n);
    check(n == 1, "R6 minimum one drive cycle without blanking", n, 1);
    trip_async = 1'b0;
    repeat (10) step();
    check_kind("R6 drive resumes once flag clears", K_DRIVE);
  endtask

  task automatic test_blank_ignore();
    int n;
    bit seen;
    off_cycles = 8'd2;
    blank_cycles = 4'd5;
    repeat (4) step();
    pulse_trip();
    step();
    step();
    run_len(K_OFF, n);
    check(n == 2, "R3 off length 2", n, 2);
    pulse_trip();
    seen = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (kind() == K_OFF) seen = 1'b1;
      step();
    end
    check(!seen, "R7 flag inside blanking ignored", seen, 0);
    pulse_trip();
    step();
    step();
    check_kind("R1 flag after blanking honoured", K_OFF);
  endtask

  task automatic test_off_resample();
    int n;
    blank_cycles = 4'd0;
    off_cycles = 8'd6;
    repeat (8) step();
    pulse_trip();
    step();
    step();
    check_kind("R1 off onset before reprogram", K_OFF);
    off_cycles = 8'd2;
    run_len(K_OFF, n);
    check(n == 6, "R10 mid-phase change ignored", n, 6);
    repeat (4) step();
    pulse_trip();
    step();
    step();
    run_len(K_OFF, n);
    check(n == 2, "R10 new value on next phase", n, 2);
  endtask

  task automatic test_direction();
    repeat (4) step();
    dir_sel = 1'b0;
    #1;
    check(dir_o == 1'b1, "R5 direction still registered", dir_o, 1);
    step();
    check_kind("R5 drive after reversal", K_DRIVE);
    check(dir_o == 1'b0, "R5 direction reversed", dir_o, 0);
    pulse_trip();
    step();
    step();
    check_kind("R2 off phase with reverse select", K_OFF);
    check(dir_o == 1'b1, "R2 short through upper pair", dir_o, 1);
  endtask

  task automatic test_disable();
    bit bad;
    off_cycles = 8'd20;
    repeat (6) step();
    pulse_trip();
    step();
    step();
    check_kind("R1 off before disable", K_OFF);
    enable = 1'b0;
    step();
    check_kind("R8 disable parks bridge", K_IDLE);
    bad = 1'b0;
    pulse_trip();
    for (int i = 0; i < 6; i++) begin
      if (kind() != K_IDLE) bad = 1'b1;
      step();
    end
    check(!bad, "R8 flag ignored while disabled", bad, 0);
    dir_sel = 1'b1;
    enable = 1'b1;
    step();
    check_kind("R8 drive on re-enable", K_DRIVE);
    check(dir_o == 1'b1, "R5 direction on re-enable", dir_o, 1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step();
    test_reset();
    test_enable_entry();
    test_trip_latency();
    test_zero_off();
    test_held_high();
    test_blank_ignore();
    test_off_resample();
    test_direction();
    test_disable();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule